// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a bank of raw interrupt input levels into the request vector that the priority logic of an interrupt controller reads. Each input first passes through a two-stage synchronizer. Each line is then either level sensitive, so its request follows the synchronized input, or edge sensitive, so its request latches on a low-to-high transition and holds until it is acknowledged.

The trigger mode of a line comes from a per-line trigger-select register. A global level flag, loaded by the initialization strobe, overrides that register and makes every line level sensitive. When software writes the trigger-select register, only the bits allowed by a fixed per-instance writable mask are stored. An acknowledge strobe carries a line number. It clears that line's request only when the line is edge sensitive. The initialization strobe clears the requests and the remembered input states, and it leaves the trigger-select register as it was.

Top module: `irq_req_latch`

## Requirements
- R1: After reset the request vector `req` is all zero and `trig_rd_data` reads zero.
- R2: An input change reaches `req` on the third rising clock edge after it is applied. The first two edges only load the synchronizer.
- R3: A line is level sensitive when the global level flag is 1 or its trigger-select bit is 1. Otherwise it is edge sensitive.
- R4: On a level-sensitive line, the request bit equals the synchronized input, so it falls when the input falls.
- R5: On an edge-sensitive line, the request bit sets when the synchronized input is high and was low on the previous cycle. It stays set when the input falls. It does not set again until the input has gone low and then high again.
- R6: A pulse on `ack_stb` clears bit `ack_line` of `req` on the next edge if that line is edge sensitive. On a level-sensitive line it has no effect.
- R7: If an acknowledge and a new rising input on the same edge-sensitive line arrive in the same cycle, the request stays set.
- R8: A write through `trig_wr_en` stores `trig_wr_data & WR_MASK`, and `trig_rd_data` returns the stored value. With the default mask 8'hFB, bit 2 stays 0, so line 2 is always edge sensitive unless the global flag is set.
- R9: A pulse on `init_stb` clears `req` and every remembered input state on the next edge. It loads the global level flag from `init_level` and leaves the trigger-select register unchanged.
- R10: Reset clears both the trigger-select register and the global level flag, so every line becomes edge sensitive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_LINES | Raw interrupt input levels |
| trig_wr_en | input | 1 | Write strobe for the trigger-select register |
| trig_wr_data | input | N_LINES | Write data; a 1 selects level mode |
| trig_rd_data | output | N_LINES | Stored trigger-select value |
| ack_stb | input | 1 | Acknowledge strobe |
| ack_line | input | $clog2(N_LINES) | Line number being acknowledged |
| init_stb | input | 1 | Initialization strobe |
| init_level | input | 1 | Global level flag loaded on `init_stb` |
| req | output | N_LINES | Request vector |

## Verification
Assertions check on every cycle that a level-sensitive request copies the previous synchronized input, that an edge-sensitive rising transition sets its request, and that an edge-sensitive request holds until it is acknowledged. They also check that an acknowledge with no competing set clears the request, that the initialization strobe empties the vector, and that a register write lands masked. Other behaviours need the bench's scenarios: the three-edge input latency, the refusal to retrigger on an input that stays high, the tie between a set and an acknowledge arriving together, and the global override together with the later reset clearing it.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/irql_sync.sv
module irql_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/irql_mode_regs.sv
module irql_mode_regs #(
  parameter int          W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         init_stb,
  input  logic         init_level,
  output logic [W-1:0] sel_q,
  output logic         glb_level_q
);
  logic [W-1:0] sel_d;
  logic         glb_d;

  always_comb begin
    sel_d = sel_q;
    glb_d = glb_level_q;
    if (wr_en)    sel_d = wr_data & MASK;
    if (init_stb) glb_d = init_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q       <= '0;
      glb_level_q <= 1'b0;
    end else begin
      sel_q       <= sel_d;
      glb_level_q <= glb_d;
    end
  end

  p_masked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sel_q == ($past(wr_data) & MASK)));
endmodule

// File: rtl/irql_line_cell.sv
module irql_line_cell
  import irq_latch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_s,
  input  trig_mode_e mode,
  input  logic       ack_hit,
  input  logic       init_clr,
  output logic       req_q
);
  logic seen_q;
  logic req_d;
  logic seen_d;
  logic rise;

  assign rise = in_s & ~seen_q;

  always_comb begin
    req_d  = req_q;
    seen_d = in_s;
    if (init_clr) begin
      req_d  = 1'b0;
      seen_d = 1'b0;
    end else if (mode == TRIG_LEVEL) begin
      req_d = in_s;
    end else begin
      req_d = rise | (req_q & ~ack_hit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      seen_q <= seen_d;
    end
  end

  p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LEVEL && !init_clr) |=> (req_q == $past(in_s)));
  p_edge_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && rise) |=> req_q);
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && !ack_hit && req_q) |=> req_q);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_EDGE && !init_clr && ack_hit && !rise) |=> !req_q);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
#(
  parameter int                 N_LINES = 8,
  parameter logic [N_LINES-1:0] WR_MASK = 8'hFB,
  localparam int                ACK_W   = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic               trig_wr_en,
  input  logic [N_LINES-1:0] trig_wr_data,
  output logic [N_LINES-1:0] trig_rd_data,
  input  logic               ack_stb,
  input  logic [ACK_W-1:0]   ack_line,
  input  logic               init_stb,
  input  logic               init_level,
  output logic [N_LINES-1:0] req
);
  logic [N_LINES-1:0] in_sync;
  logic [N_LINES-1:0] sel_q;
  logic               glb_level;

  irql_sync #(.W(N_LINES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (irq_in),
    .d_sync  (in_sync)
  );

  irql_mode_regs #(.W(N_LINES), .MASK(WR_MASK)) u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (trig_wr_en),
    .wr_data     (trig_wr_data),
    .init_stb    (init_stb),
    .init_level  (init_level),
    .sel_q       (sel_q),
    .glb_level_q (glb_level)
  );

  assign trig_rd_data = sel_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    trig_mode_e mode_i;
    logic       ack_i;
    assign mode_i = (glb_level | sel_q[i]) ? TRIG_LEVEL : TRIG_EDGE;
    assign ack_i  = ack_stb && (ack_line == ACK_W'(i));

    irql_line_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_s     (in_sync[i]),
      .mode     (mode_i),
      .ack_hit  (ack_i),
      .init_clr (init_stb),
      .req_q    (req[i])
    );
  end

  p_init_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |=> (req == '0));
  p_init_keeps_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_stb && !trig_wr_en) |=> $stable(trig_rd_data));
endmodule

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq_in;
  logic       trig_wr_en;
  logic [7:0] trig_wr_data;
  logic [7:0] trig_rd_data;
  logic       ack_stb;
  logic [2:0] ack_line;
  logic       init_stb;
  logic       init_level;
  logic [7:0] req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  irq_req_latch dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
    .trig_rd_data(trig_rd_data), .ack_stb(ack_stb), .ack_line(ack_line),
    .init_stb(init_stb), .init_level(init_level), .req(req)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_ack(input logic [2:0] line);
    ack_stb = 1'b1; ack_line = line;
    tick(1);
    ack_stb = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 req after reset", req, 8'h00);
    chk("R1 trig_rd after reset", trig_rd_data, 8'h00);
  endtask

  task automatic t_edge();
    irq_in = 8'h01;
    tick(2);
    chk("R2 not yet visible after two edges", req, 8'h00);
    tick(1);
    chk("R2 visible on third edge", req, 8'h01);
    irq_in = 8'h00;
    tick(3);
    chk("R5 edge request holds after input low", req, 8'h01);
    do_ack(3'd0);
    chk("R6 ack clears edge line", req, 8'h00);
    irq_in = 8'h01;
    tick(3);
    chk("R5 set again after low-high", req, 8'h01);
    do_ack(3'd0);
    tick(4);
    chk("R5 no retrigger while input stays high", req, 8'h00);
    irq_in = 8'h00;
    tick(3);
  endtask

  task automatic t_level();
    trig_wr_en = 1'b1; trig_wr_data = 8'hFF;
    tick(1);
    trig_wr_en = 1'b0;
    chk("R8 masked write read back", trig_rd_data, 8'hFB);
    irq_in = 8'h02;
    tick(3);
    chk("R4 level line follows high", req, 8'h02);
    do_ack(3'd1);
    chk("R6 ack on level line ignored", req, 8'h02);
    irq_in = 8'h00;
    tick(3);
    chk("R4 level line falls with input", req, 8'h00);
    irq_in = 8'h04;
    tick(3);
    irq_in = 8'h00;
    tick(3);
    chk("R3 masked line 2 stays edge", req, 8'h04);
    do_ack(3'd2);
    chk("R6 ack clears masked edge line", req, 8'h00);
  endtask

  task automatic t_set_wins();
    trig_wr_en = 1'b1; trig_wr_data = 8'h00;
    tick(1);
    trig_wr_en = 1'b0;
    irq_in = 8'h08;
    tick(3);
    irq_in = 8'h00;
    tick(3);
    chk("R5 line 3 latched", req, 8'h08);
    irq_in = 8'h08;
    tick(2);
    do_ack(3'd3);
    chk("R7 set wins over simultaneous ack", req, 8'h08);
    do_ack(3'd3);
    chk("R6 later ack clears", req, 8'h00);
    irq_in = 8'h00;
    tick(3);
  endtask

  task automatic t_init();
    trig_wr_en = 1'b1; trig_wr_data = 8'h20;
    tick(1);
    trig_wr_en = 1'b0;
    irq_in = 8'h01;
    tick(3);
    chk("R5 edge request before init", req, 8'h01);
    init_stb = 1'b1; init_level = 1'b1;
    tick(1);
    init_stb = 1'b0; init_level = 1'b0;
    chk("R9 init clears requests", req, 8'h00);
    chk("R9 init keeps trigger select", trig_rd_data, 8'h20);
    irq_in = 8'h00;
    tick(3);
    irq_in = 8'h10;
    tick(3);
    chk("R3 global flag level high", req, 8'h10);
    irq_in = 8'h00;
    tick(3);
    chk("R3 global flag level falls", req, 8'h00);
  endtask

  task automatic t_reset_modes();
    do_reset();
    chk("R10 reset clears trigger select", trig_rd_data, 8'h00);
    irq_in = 8'h20;
    tick(3);
    irq_in = 8'h00;
    tick(3);
    chk("R10 line 5 edge after reset", req, 8'h20);
  endtask

  initial begin
    rst_n = 1'b0; irq_in = '0; trig_wr_en = 1'b0; trig_wr_data = '0;
    ack_stb = 1'b0; ack_line = '0; init_stb = 1'b0; init_level = 1'b0;
    tick(1);
    do_reset();
    t_reset();
    t_edge();
    t_level();
    t_set_wins();
    t_init();
    t_reset_modes();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule